// File: doc/BRIEF.md
# Two-Digit Decimal Clock Divider

This block produces a strobe every N cycles of its clock, where N is a two-digit decimal number from 1 to 99. N is given as packed BCD. Inside are two decade stages that count down in a chain. The units stage steps on every clock edge. The tens stage steps only when the units stage signals, through its active-low carry, that it is at zero. When the chained count reaches its last state, both stages reload from the ratio input. The output then carries a single-cycle pulse, so the strobe rate is the clock rate divided by N.

A ratio that is not a valid BCD value, or a ratio of zero, sets an error flag. The divider is held cleared while that condition lasts. The ratio input is read only at a reload, so a new value never cuts short the period in progress.

Top module: `bcd_freq_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `pulse_o` and `cfg_err_o` are 0 after that edge, whatever the ratio input holds.
- R2: The ratio is packed BCD, with the units digit in bits 3:0 and the tens digit in bits 7:4. For every ratio N from 1 to 99, the rising edges of `pulse_o` (for N=1, the cycles in which it is high) are N clock cycles apart.
- R3: For N of 2 or more, `pulse_o` is high for exactly one cycle per period. For N=1 it stays high on every cycle.
- R4: The units digit counts down and wraps from 0 to 9. The tens digit changes only at a reload or when the units digit is 0. Ratios that are multiples of ten therefore still give periods of exactly N.
- R5: After `rst` falls, or after an error clears, the first pulse is sampled N+1 cycles later. One cycle loads the cleared counter, and then a full period of N follows.
- R6: A ratio of 0x00 sets `cfg_err_o` one edge later. It keeps `pulse_o` low for as long as the ratio stays at zero. Once a valid ratio returns, `cfg_err_o` clears at the next edge and pulses resume as in R5.
- R7: A ratio with either nibble above 9 is treated exactly as in R6.
- R8: A ratio written in the middle of a period does not change that period. The period after the next pulse uses the new value.

Assertions:
- AST_DIGIT_IN_RANGE — R4: each digit stays at 9 or below.
- AST_HOLD_WHEN_IDLE — R4: a digit that is not enabled and not loading keeps its value.
- AST_LOAD_TAKES_RATIO — R8: a reload loads the ratio present at that edge.
- AST_TENS_WAITS — R4: the upper digits do not move while the units digit is nonzero.
- AST_ERR_SILENT — R6: no pulse while the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 8 | Divide ratio, packed BCD (tens in bits 7:4, units in bits 3:0) |
| pulse_o | output | 1 | One-cycle strobe at each reload |
| cfg_err_o | output | 1 | High while the ratio is zero or not valid BCD |

## Verification
The assertions check the following on every cycle:
- each digit stays in decimal range;
- a disabled digit holds its value;
- the tens digit waits for the units digit to reach zero;
- a reload captures the ratio present at that edge;
- the error flag and the pulse are never high together.

Only the bench's scenarios can show the end-to-end timing:
- the exact period for all 99 ratios;
- the N+1 latency after reset or after an error clears;
- the pulse width;
- the rule that a ratio change is deferred to the next period.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        logic clear;     // hold the chain at zero
        logic reload;    // load all digits from the ratio
        logic at_one;    // chained count equals one
    } div_ctrl_t;

    function automatic logic digit_ok(input bcd_digit_t d);
        return d <= DIGIT_MAX;
    endfunction

    function automatic bcd_digit_t digit_dec(input bcd_digit_t d);
        return (d == '0) ? DIGIT_MAX : bcd_digit_t'(d - 4'd1);
    endfunction
endpackage

// File: rtl/bcd_decade_down.sv
module bcd_decade_down
    import bcd_div_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       load,
    input  bcd_digit_t preset,
    input  logic       cin_n,
    output bcd_digit_t q,
    output logic       cout_n
);
    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (load)
            q <= preset;
        else if (!cin_n)
            q <= digit_dec(q);
    end

    // Active-low carry: this digit is at zero and is itself enabled.
    assign cout_n = !((q == '0) && !cin_n);

    AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
        q <= DIGIT_MAX); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (clr)
        (!load && cin_n) |=> $stable(q)); // R4
endmodule

// File: rtl/bcd_ratio_check.sv
module bcd_ratio_check
    import bcd_div_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int RATIO_W = DIGITS * DIGIT_W
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic               bad
);
    logic any_bad_digit;

    always_comb begin
        any_bad_digit = 1'b0;
        for (int i = 0; i < DIGITS; i++) begin
            if (!digit_ok(ratio[i*DIGIT_W +: DIGIT_W]))
                any_bad_digit = 1'b1;
        end
    end

    assign bad = any_bad_digit || (ratio == '0);
endmodule

// File: rtl/bcd_freq_divider.sv
module bcd_freq_divider
    import bcd_div_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int RATIO_W = DIGITS * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               pulse_o,
    output logic               cfg_err_o
);
    logic               ratio_bad;
    logic               upper_zero;
    logic [RATIO_W-1:0] count_flat;
    logic [DIGITS-1:0]  cin_n;
    logic [DIGITS-1:0]  cout_n;
    bcd_digit_t         q [DIGITS];
    div_ctrl_t          ctl;

    bcd_ratio_check #(.DIGITS(DIGITS)) u_chk (
        .ratio (ratio_i),
        .bad   (ratio_bad)
    );

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        if (g == 0) begin : g_lsd
            assign cin_n[g] = 1'b0;
        end else begin : g_upper
            assign cin_n[g] = cout_n[g-1];
        end

        bcd_decade_down u_stage (
            .clk    (clk),
            .clr    (ctl.clear),
            .load   (ctl.reload),
            .preset (ratio_i[g*DIGIT_W +: DIGIT_W]),
            .cin_n  (cin_n[g]),
            .q      (q[g]),
            .cout_n (cout_n[g])
        );

        assign count_flat[g*DIGIT_W +: DIGIT_W] = q[g];
    end

    always_comb begin
        upper_zero = 1'b1;
        for (int i = 1; i < DIGITS; i++) begin
            if (q[i] != '0)
                upper_zero = 1'b0;
        end
    end

    // The last carry of the chain is low only when every digit is zero.
    assign ctl.clear  = rst || ratio_bad;
    assign ctl.at_one = upper_zero && (q[0] == 4'd1);
    assign ctl.reload = ctl.at_one || !cout_n[DIGITS-1];

    always_ff @(posedge clk) begin
        if (ctl.clear)
            pulse_o <= 1'b0;
        else
            pulse_o <= ctl.at_one;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err_o <= 1'b0;
        else
            cfg_err_o <= ratio_bad;
    end

    AST_LOAD_TAKES_RATIO: assert property (@(posedge clk) disable iff (ctl.clear)
        ctl.reload |=> (count_flat == $past(ratio_i))); // R8

    if (DIGITS > 1) begin : g_tens_chk
        AST_TENS_WAITS: assert property (@(posedge clk) disable iff (ctl.clear)
            (!ctl.reload && (q[0] != '0)) |=> $stable(count_flat[RATIO_W-1:DIGIT_W])); // R4
    end

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> !pulse_o); // R6
endmodule

// File: tb/tb_bcd_freq_divider.sv
module tb_bcd_freq_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ratio_i = 8'h12;
    logic       pulse_o;
    logic       cfg_err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    bcd_freq_divider dut (
        .clk       (clk),
        .rst       (rst),
        .ratio_i   (ratio_i),
        .pulse_o   (pulse_o),
        .cfg_err_o (cfg_err_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    // Counts falling edges until pulse_o is seen high.
    task automatic next_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse_o && n < 400);
    endtask

    task automatic t_reset();
        int n;
        ratio_i = 8'h00;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
        chk(cfg_err_o == 1'b0, "R1 err in reset", int'(cfg_err_o), 0);
        ratio_i = 8'h12;
        @(negedge clk);
        rst = 1'b0;
        next_pulse(n);
        chk(n == 13, "R5 first pulse after reset", n, 13);
    endtask

    task automatic t_sweep();
        int n;
        for (int r = 1; r <= 99; r++) begin
            @(negedge clk);
            ratio_i = to_bcd(r);
            next_pulse(n);
            next_pulse(n);
            chk(n == r, (r % 10 == 0) ? "R4 period tens step" : "R2 period", n, r);
        end
    endtask

    task automatic t_width();
        int n;
        int highs;
        @(negedge clk);
        ratio_i = 8'h05;
        next_pulse(n);
        next_pulse(n);
        @(negedge clk);
        chk(pulse_o == 1'b0, "R3 pulse one cycle", int'(pulse_o), 0);
        highs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pulse_o) highs++;
        end
        chk(highs == 10, "R3 pulses in 50 cycles", highs, 10);
        ratio_i = 8'h01;
        next_pulse(n);
        next_pulse(n);
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pulse_o) highs++;
        end
        chk(highs == 10, "R3 ratio one stays high", highs, 10);
    endtask

    task automatic t_bad(input logic [7:0] v, input string req);
        int n;
        int seen;
        @(negedge clk);
        ratio_i = v;
        @(negedge clk);
        chk(cfg_err_o == 1'b1, req, int'(cfg_err_o), 1);
        chk(pulse_o == 1'b0, req, int'(pulse_o), 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pulse_o || !cfg_err_o) seen++;
        end
        chk(seen == 0, req, seen, 0);
        ratio_i = 8'h25;
        next_pulse(n);
        chk(n == 26, "R5 first pulse after error", n, 26);
        chk(cfg_err_o == 1'b0, req, int'(cfg_err_o), 0);
    endtask

    task automatic t_change();
        int n;
        @(negedge clk);
        ratio_i = 8'h07;
        next_pulse(n);
        next_pulse(n);
        chk(n == 7, "R8 base period", n, 7);
        repeat (2) @(negedge clk);
        ratio_i = 8'h03;
        next_pulse(n);
        chk(n == 5, "R8 current period kept", n, 5);
        next_pulse(n);
        chk(n == 3, "R8 new period", n, 3);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_width();
        t_bad(8'h00, "R6 zero ratio");
        t_bad(8'h1A, "R7 bad units nibble");
        t_bad(8'hA1, "R7 bad tens nibble");
        t_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule